// File: doc/BRIEF.md
# Descriptor-Chained Transmit Queue Engine

This engine serves one transmit endpoint. Software builds a chain of 16-byte descriptors in memory, each naming a data buffer, a byte count and the address of the following descriptor. Software then starts the queue at the first descriptor. The engine reads each descriptor through a simple word-wide memory port. It sends the buffer bytes on a valid/ready byte stream, writes the descriptor's flag word back with the ownership bit cleared, and moves on along the next pointer.

Ownership is handed over one descriptor at a time. A descriptor whose ownership bit is clear parks the engine: the queue stays active, the descriptor is not touched, and a resume command makes the engine read it again. Flag bits in each descriptor select skipping without data, a trailing zero-length packet, and a completion pulse. A descriptor with no bytes to send raises a length-error pulse and stalls the queue. Software repairs that descriptor, for example by marking it to be skipped, and then resumes. The current-descriptor output always names the descriptor the engine will handle next, so software can tell which descriptors have completed.

Top module: `txq_engine`

## Requirements
- R1: After reset the queue is inactive, the current-descriptor address and the warning flag are zero, and no memory request, stream beat or pulse is issued.
- R2: A descriptor occupies 16 bytes at a 16-byte-aligned byte address D. Offset D+0 holds the flag word, D+4 the buffer byte address, D+8 the next-descriptor address, and D+12 the byte count in bits 15:0. The memory port is 32 bits wide and byte-addressed. Read data is valid in the cycle after the request.
- R3: Flag bit 0 is the ownership bit. A descriptor with bit 0 clear is not processed. The queue stays active, the current address stays on that descriptor, and nothing is sent. A later resume reads that descriptor again.
- R4: A descriptor with bit 0 set, bit 2 clear and a nonzero count sends exactly that many bytes from the buffer address upward, at any byte alignment. Byte k of a memory word is data bits 8k+7:8k. tx_last marks the final data byte. While tx_ready is low, a pending beat and its data, last and zero-length markers hold steady.
- R5: When a descriptor is finished, the engine writes to D+0 the flag word as read, with only bit 0 cleared. The current-descriptor address then takes the next pointer.
- R6: If flag bit 7 is set, done_pulse is high for exactly one cycle after that descriptor's write-back. No pulse is raised when bit 7 is clear.
- R7: If flag bit 6 is set and zlp_en is high, one extra beat with tx_zlp=1, tx_last=1 and tx_data=0 follows the data bytes. With zlp_en low, no such beat is sent.
- R8: If flag bit 2 is set, no bytes are sent whatever the count. The descriptor is written back as in R5 and the chain is followed.
- R9: A descriptor with bit 0 set, bit 2 clear and a zero count raises len_err_pulse for one cycle and sends nothing. The descriptor is not written back, the queue stays active and the current address stays on it. A resume reads it again.
- R10: cmd_start while inactive loads start_addr as the current address and makes the queue active. cmd_start while active is ignored and sets warn_start_active, which stays set until reset.
- R11: cmd_stop while active lets the descriptor in flight finish, then clears q_active without reading another descriptor. cmd_resume while inactive makes the queue active again and reads the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | ADDR_W | First descriptor address for a start |
| zlp_en | input | 1 | Allows trailing zero-length packets |
| q_active | output | 1 | Queue active flag |
| cur_desc_addr | output | ADDR_W | Descriptor to be handled next |
| warn_start_active | output | 1 | Sticky flag: start seen while active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream beat valid |
| tx_last | output | 1 | Final beat of a descriptor's data |
| tx_zlp | output | 1 | Beat is a zero-length packet marker |
| tx_ready | input | 1 | Stream sink ready |
| done_pulse | output | 1 | Completion pulse |
| len_err_pulse | output | 1 | Zero-count error pulse |

## Verification
The main sweep chains 36 descriptors that cover every buffer alignment from 0 to 3 with byte counts from 1 to 9, under pseudo-random backpressure. This shows whether the engine refills its word at the right boundary and stops at the exact count. Completion and zero-length flags alternate with different periods, and one descriptor carries a spare flag bit, so a flag read from the wrong word or lost on write-back leads to a miscompare. Separate chains hold an unowned descriptor, a zero-count descriptor that is later marked to be skipped, a skipped descriptor with a nonzero count, and a stop issued in the middle of a transfer. Each one tells a park apart from a stall, a skip and a shutdown by the current address, the active flag and the written-back flag word.

// File: rtl/txq_pkg.sv
// Shared constants and state encoding for the transmit queue engine.
// Assumes a 32-bit memory word and byte-wide stream.
package txq_pkg;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int BSEL_W         = $clog2(BYTES_PER_WORD);
    localparam int DESC_WORDS     = 4;
    localparam int LEN_W          = 16;

    // Flag word bit positions (decoded by software and engine alike)
    localparam int FLG_OWN  = 0;
    localparam int FLG_SKIP = 2;
    localparam int FLG_ZLP  = 6;
    localparam int FLG_IRQ  = 7;

    // Word indices inside a descriptor
    localparam logic [1:0] WI_FLAGS = 2'd0;
    localparam logic [1:0] WI_BUF   = 2'd1;
    localparam logic [1:0] WI_NEXT  = 2'd2;
    localparam logic [1:0] WI_LEN   = 2'd3;

    typedef enum logic [3:0] {
        SQ_IDLE,   // parked: inactive, unowned descriptor, or length stall
        SQ_RD,     // issue descriptor word read
        SQ_CAP,    // capture descriptor word
        SQ_EVAL,   // decide skip / error / send
        SQ_LOAD,   // issue buffer word read
        SQ_LCAP,   // capture buffer word into byte lane
        SQ_SEND,   // emit data bytes
        SQ_ZLP,    // emit zero-length marker beat
        SQ_WB,     // write flag word back
        SQ_ADV     // follow next pointer
    } seq_state_e;
endpackage

// File: rtl/txq_cmd.sv
// Command and status holder: active flag, current descriptor address,
// sticky warning and pending stop. Assumes the sequencer reports when it is
// parked and when it advances along the chain.
module txq_cmd
    #(parameter int ADDR_W = 16)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_resume,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              seq_parked,
    input  logic              seq_adv,
    input  logic [ADDR_W-1:0] seq_next,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              warn,
    output logic              stop_pend,
    output logic              go
);
    // Fetch kick: fresh start, or resume whenever the sequencer is parked
    assign go = (cmd_start && !active) || (cmd_resume && seq_parked);

    // Command state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cur_addr  <= '0;
            warn      <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (cmd_start && active)
                warn <= 1'b1;
            if (cmd_start && !active)
                cur_addr <= start_addr;
            else if (seq_adv)
                cur_addr <= seq_next;
            if (go) begin
                active    <= 1'b1;
                stop_pend <= 1'b0;
            end else if (stop_pend && seq_parked) begin
                active    <= 1'b0;
                stop_pend <= 1'b0;
            end else if (cmd_stop && active) begin
                stop_pend <= 1'b1;
            end
        end
    end

    // R10
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(warn));

    // R11
    off_only_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(seq_parked));
endmodule

// File: rtl/txq_byte_lane.sv
// Output byte lane: holds one memory word and presents the selected byte
// (or a zero-length marker) on the stream. Assumes the sequencer keeps
// load/select/send steady while the sink stalls.
module txq_byte_lane
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [BSEL_W-1:0] sel,
    input  logic              send_data,
    input  logic              send_zlp,
    input  logic              last_in,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_zlp
);
    logic [WORD_W-1:0] word_q;
    logic [7:0]        lanes [BYTES_PER_WORD];

    // Word holding register
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (load)
            word_q <= word_in;
    end

    // Split the held word into little-endian byte lanes
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_lane
        assign lanes[b] = word_q[8*b +: 8];
    end

    // Stream outputs
    always_comb begin
        tx_valid = send_data || send_zlp;
        tx_zlp   = send_zlp;
        tx_last  = last_in;
        tx_data  = send_zlp ? 8'h00 : lanes[sel];
    end
endmodule

// File: rtl/txq_seq.sv
// Descriptor sequencer: reads a descriptor word by word, then skips, flags a
// length error, or streams the buffer, then writes the flag word back and
// follows the next pointer. Assumes ADDR_W <= 32, 16-byte-aligned descriptors
// and one-cycle read latency.
module txq_seq
    import txq_pkg::*;
    #(parameter int ADDR_W = 16)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop_pend,
    input  logic              zlp_en,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              tx_ready,
    output logic              parked,
    output logic              adv,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              lane_load,
    output logic [BSEL_W-1:0] lane_sel,
    output logic              send_data,
    output logic              send_zlp,
    output logic              last_beat,
    output logic              done,
    output logic              len_err
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << FLG_OWN;

    seq_state_e        state;
    logic [1:0]        widx;
    logic [WORD_W-1:0] flags_q;
    logic [ADDR_W-1:0] bufp;
    logic [ADDR_W-1:0] nxt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rem;
    logic              zlp_wanted;

    assign zlp_wanted = flags_q[FLG_ZLP] && zlp_en;

    // Memory port drive
    always_comb begin
        mem_req   = (state == SQ_RD) || (state == SQ_LOAD) || (state == SQ_WB);
        mem_we    = (state == SQ_WB);
        mem_wdata = (state == SQ_WB) ? (flags_q & ~OWN_MASK) : '0;
        case (state)
            SQ_RD:   mem_addr = cur_addr + {{(ADDR_W-4){1'b0}}, widx, 2'b00};
            SQ_LOAD: mem_addr = {bufp[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
            SQ_WB:   mem_addr = cur_addr;
            default: mem_addr = '0;
        endcase
    end

    // Status and stream control decode
    always_comb begin
        parked    = (state == SQ_IDLE);
        adv       = (state == SQ_ADV);
        next_ptr  = nxt;
        lane_load = (state == SQ_LCAP);
        lane_sel  = bufp[BSEL_W-1:0];
        send_data = (state == SQ_SEND);
        send_zlp  = (state == SQ_ZLP);
        last_beat = ((state == SQ_SEND) && (rem == LEN_W'(1))) || (state == SQ_ZLP);
        done      = (state == SQ_ADV) && flags_q[FLG_IRQ];
        len_err   = (state == SQ_EVAL) && !flags_q[FLG_SKIP] && (len_q == '0);
    end

    // Sequencer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            widx    <= '0;
            flags_q <= '0;
            bufp    <= '0;
            nxt     <= '0;
            len_q   <= '0;
            rem     <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        widx  <= WI_FLAGS;
                        state <= SQ_RD;
                    end
                end
                SQ_RD: state <= SQ_CAP;
                SQ_CAP: begin
                    case (widx)
                        WI_FLAGS: flags_q <= mem_rdata;
                        WI_BUF:   bufp    <= mem_rdata[ADDR_W-1:0];
                        WI_NEXT:  nxt     <= mem_rdata[ADDR_W-1:0];
                        default:  len_q   <= mem_rdata[LEN_W-1:0];
                    endcase
                    if (widx == WI_FLAGS && !mem_rdata[FLG_OWN]) begin
                        state <= SQ_IDLE;
                    end else if (widx == WI_LEN) begin
                        state <= SQ_EVAL;
                    end else begin
                        widx  <= widx + 2'd1;
                        state <= SQ_RD;
                    end
                end
                SQ_EVAL: begin
                    if (flags_q[FLG_SKIP])
                        state <= SQ_WB;
                    else if (len_q == '0)
                        state <= SQ_IDLE;
                    else begin
                        rem   <= len_q;
                        state <= SQ_LOAD;
                    end
                end
                SQ_LOAD: state <= SQ_LCAP;
                SQ_LCAP: state <= SQ_SEND;
                SQ_SEND: begin
                    if (tx_ready) begin
                        bufp <= bufp + ADDR_W'(1);
                        rem  <= rem - LEN_W'(1);
                        if (rem == LEN_W'(1))
                            state <= zlp_wanted ? SQ_ZLP : SQ_WB;
                        else if (bufp[BSEL_W-1:0] == {BSEL_W{1'b1}})
                            state <= SQ_LOAD;
                    end
                end
                SQ_ZLP: begin
                    if (tx_ready)
                        state <= SQ_WB;
                end
                SQ_WB: state <= SQ_ADV;
                SQ_ADV: begin
                    if (stop_pend) begin
                        state <= SQ_IDLE;
                    end else begin
                        widx  <= WI_FLAGS;
                        state <= SQ_RD;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txq_engine.sv
// Top of the descriptor-chained transmit queue engine. Wires the command
// holder, the descriptor sequencer and the output byte lane together.
// Assumes a single-cycle-latency memory with no stall.
module txq_engine
    import txq_pkg::*;
    #(parameter int ADDR_W = 16)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_resume,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              zlp_en,
    output logic              q_active,
    output logic [ADDR_W-1:0] cur_desc_addr,
    output logic              warn_start_active,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_zlp,
    input  logic              tx_ready,
    output logic              done_pulse,
    output logic              len_err_pulse
);
    logic              parked;
    logic              adv;
    logic [ADDR_W-1:0] next_ptr;
    logic              stop_pend;
    logic              go;
    logic              lane_load;
    logic [BSEL_W-1:0] lane_sel;
    logic              send_data;
    logic              send_zlp;
    logic              last_beat;

    txq_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_resume (cmd_resume),
        .start_addr (start_addr),
        .seq_parked (parked),
        .seq_adv    (adv),
        .seq_next   (next_ptr),
        .active     (q_active),
        .cur_addr   (cur_desc_addr),
        .warn       (warn_start_active),
        .stop_pend  (stop_pend),
        .go         (go)
    );

    txq_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .stop_pend  (stop_pend),
        .zlp_en     (zlp_en),
        .cur_addr   (cur_desc_addr),
        .mem_rdata  (mem_rdata),
        .tx_ready   (tx_ready),
        .parked     (parked),
        .adv        (adv),
        .next_ptr   (next_ptr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .lane_load  (lane_load),
        .lane_sel   (lane_sel),
        .send_data  (send_data),
        .send_zlp   (send_zlp),
        .last_beat  (last_beat),
        .done       (done_pulse),
        .len_err    (len_err_pulse)
    );

    txq_byte_lane u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lane_load),
        .word_in   (mem_rdata),
        .sel       (lane_sel),
        .send_data (send_data),
        .send_zlp  (send_zlp),
        .last_in   (last_beat),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_zlp    (tx_zlp)
    );

    // R4
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp));

    // R5
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req && (mem_addr == cur_desc_addr));

    // R5
    advance_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_active && $past(q_active) && (cur_desc_addr != $past(cur_desc_addr))) |-> $past(mem_we, 2));

    // R11
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_active |-> !tx_valid && !mem_req);

    // R9
    stall_stays_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_pulse |=> q_active && !tx_valid && !mem_req);
endmodule

// File: tb/tb_txq_engine.sv
module tb_txq_engine;
    localparam int ADDR_W = 16;
    localparam logic [31:0] F_OWN  = 32'h1;
    localparam logic [31:0] F_SKIP = 32'h4;
    localparam logic [31:0] F_ZLP  = 32'h40;
    localparam logic [31:0] F_IRQ  = 32'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic zlp_en = 1'b1;
    logic q_active, warn_start_active;
    logic [ADDR_W-1:0] cur_desc_addr;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0] tx_data;
    logic tx_valid, tx_last, tx_zlp;
    logic tx_ready = 1'b1;
    logic done_pulse, len_err_pulse;

    always #4 clk = ~clk;

    txq_engine #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_resume(cmd_resume), .start_addr(start_addr), .zlp_en(zlp_en),
        .q_active(q_active), .cur_desc_addr(cur_desc_addr),
        .warn_start_active(warn_start_active), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp),
        .tx_ready(tx_ready), .done_pulse(done_pulse), .len_err_pulse(len_err_pulse)
    );

    // Memory model: 4 KB, one-cycle read latency, bench poke port
    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    always @(posedge clk) begin
        if (tb_we) mem[tb_wa] <= tb_wd;
        else if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end

    int vectors = 0;
    int errors = 0;
    int exp_n = 0;
    int got_n = 0;
    int done_n = 0;
    int err_n = 0;
    int zlp_n = 0;
    bit finished = 1'b0;
    logic [9:0] exp_q [0:1023];
    logic bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] pat(input int a);
        int v;
        v = a * 13 + 5;
        return v[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Backpressure pattern, changed just after each rising edge
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = bp_en ? lfsr[0] : 1'b1;
    end

    // Stream and pulse monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (got_n >= exp_n) begin
                    vectors++;
                    errors++;
                    $display("FAIL R4 unexpected beat actual=%0h expected=none", {tx_zlp, tx_last, tx_data});
                end else begin
                    check({tx_zlp, tx_last, tx_data} == exp_q[got_n], "R4/R7 beat",
                          {tx_zlp, tx_last, tx_data}, exp_q[got_n]);
                end
                if (tx_zlp) zlp_n++;
                got_n++;
            end
            if (done_pulse) done_n++;
            if (len_err_pulse) err_n++;
        end
    end

    task automatic poke(input int byte_addr, input logic [31:0] val);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_wa = 10'(byte_addr >> 2); tb_wd = val;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input int d, input logic [31:0] fl, input int b, input int nx, input int len);
        poke(d, fl); poke(d + 4, 32'(b)); poke(d + 8, 32'(nx)); poke(d + 12, 32'(len));
    endtask

    task automatic expect_desc(input int b, input int len, input bit zlp);
        for (int i = 0; i < len; i++) begin
            exp_q[exp_n] = {1'b0, (i == len - 1), pat(b + i)};
            exp_n++;
        end
        if (zlp) begin
            exp_q[exp_n] = {1'b1, 1'b1, 8'h00};
            exp_n++;
        end
    endtask

    task automatic pulse_start(input int a);
        @(posedge clk); #1; start_addr = 16'(a); cmd_start = 1'b1;
        @(posedge clk); #1; cmd_start = 1'b0;
    endtask

    task automatic pulse_resume();
        @(posedge clk); #1; cmd_resume = 1'b1;
        @(posedge clk); #1; cmd_resume = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int n = 0; n < 20000 && q < 20; n++) begin
            @(negedge clk);
            if (!mem_req && !tx_valid) q++; else q = 0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] fl [0:35];
        int d0, e0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(q_active == 1'b0, "R1 active", q_active, 0);
        check(cur_desc_addr == '0, "R1 cur", cur_desc_addr, 0);
        check(warn_start_active == 1'b0, "R1 warn", warn_start_active, 0);
        check(!tx_valid && !mem_req && !done_pulse && !len_err_pulse, "R1 quiet",
              {tx_valid, mem_req, done_pulse, len_err_pulse}, 0);

        for (int w = 512; w < 1024; w++)
            poke(4 * w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});

        // R2 R4 R5 R6 R7 sweep: alignment 0..3 x count 1..9
        for (int i = 0; i < 36; i++) begin
            int b, len;
            b = 32'h800 + 32 * i + (i % 4);
            len = 1 + i / 4;
            fl[i] = F_OWN | ((i % 2 == 0) ? F_IRQ : 32'h0) | ((i % 3 == 0) ? F_ZLP : 32'h0)
                    | ((i == 5) ? 32'h0000_1000 : 32'h0);
            put_desc(16 * i, fl[i], b, 16 * (i + 1), len);
            expect_desc(b, len, (i % 3 == 0));
        end
        put_desc(16 * 36, 32'h0, 32'hE00, 16 * 37, 4);
        bp_en = 1'b1;
        zlp_en = 1'b1;
        pulse_start(0);
        wait_quiet();
        check(got_n == exp_n, "R4 beat count", got_n, exp_n);
        check(done_n == 18, "R6 done count", done_n, 18);
        check(zlp_n == 12, "R7 zlp count", zlp_n, 12);
        check(err_n == 0, "R9 no len err", err_n, 0);
        check(cur_desc_addr == 16'h240, "R3 parked cur", cur_desc_addr, 16'h240);
        check(q_active == 1'b1, "R3 stays active", q_active, 1);
        for (int i = 0; i < 36; i++)
            check(mem[4 * i] == (fl[i] & ~F_OWN), "R5 writeback", mem[4 * i], fl[i] & ~F_OWN);

        // R10 start while active ignored, warning set
        d0 = got_n;
        pulse_start(16'h100);
        wait_quiet();
        check(warn_start_active == 1'b1, "R10 warn", warn_start_active, 1);
        check(cur_desc_addr == 16'h240, "R10 cur kept", cur_desc_addr, 16'h240);
        check(got_n == d0, "R10 no beats", got_n, d0);

        // R3 resume continues on now-owned descriptor; R7 zlp_en low
        zlp_en = 1'b0;
        d0 = done_n;
        put_desc(16'h240, F_OWN | F_IRQ | F_ZLP, 32'hE01, 16'h250, 5);
        put_desc(16'h250, 32'h0, 32'hE40, 16'h260, 0);
        expect_desc(32'hE01, 5, 1'b0);
        pulse_resume();
        wait_quiet();
        check(got_n == exp_n, "R7 no zlp when disabled", got_n, exp_n);
        check(cur_desc_addr == 16'h250, "R3 resume advance", cur_desc_addr, 16'h250);
        check(done_n == d0 + 1, "R6 done", done_n, d0 + 1);

        // R9 zero count stalls
        put_desc(16'h250, F_OWN | F_IRQ, 32'hE40, 16'h260, 0);
        put_desc(16'h260, F_OWN | F_SKIP, 32'hE40, 16'h270, 4);
        put_desc(16'h270, 32'h0, 32'hE80, 16'h280, 9);
        d0 = done_n;
        pulse_resume();
        wait_quiet();
        check(err_n == 1, "R9 len err pulse", err_n, 1);
        check(cur_desc_addr == 16'h250, "R9 cur kept", cur_desc_addr, 16'h250);
        check(q_active == 1'b1, "R9 active", q_active, 1);
        check(mem[16'h250 >> 2] == (F_OWN | F_IRQ), "R9 no writeback", mem[16'h250 >> 2], F_OWN | F_IRQ);
        check(done_n == d0, "R9 no done", done_n, d0);
        check(got_n == exp_n, "R9 no beats", got_n, exp_n);

        // R8 mark skipped and resume: both skipped descriptors pass with no data
        poke(16'h250, F_OWN | F_IRQ | F_SKIP);
        pulse_resume();
        wait_quiet();
        check(cur_desc_addr == 16'h270, "R8 skip advance", cur_desc_addr, 16'h270);
        check(got_n == exp_n, "R8 no beats", got_n, exp_n);
        check(mem[16'h250 >> 2] == (F_IRQ | F_SKIP), "R8 writeback", mem[16'h250 >> 2], F_IRQ | F_SKIP);
        check(mem[16'h260 >> 2] == F_SKIP, "R8 writeback count>0", mem[16'h260 >> 2], F_SKIP);
        check(done_n == d0 + 1, "R6 done on skip", done_n, d0 + 1);
        check(err_n == 1, "R9 err once", err_n, 1);

        // R11 stop mid-transfer
        put_desc(16'h270, F_OWN, 32'hE80, 16'h280, 9);
        put_desc(16'h280, F_OWN, 32'hEA0, 16'h290, 3);
        put_desc(16'h290, 32'h0, 32'hEC0, 16'h2A0, 1);
        expect_desc(32'hE80, 9, 1'b0);
        pulse_resume();
        cmd_stop = 1'b1;
        @(posedge clk); #1; cmd_stop = 1'b0;
        wait_quiet();
        check(q_active == 1'b0, "R11 stopped", q_active, 0);
        check(cur_desc_addr == 16'h280, "R11 cur after stop", cur_desc_addr, 16'h280);
        check(got_n == exp_n, "R11 in-flight finished", got_n, exp_n);
        check(mem[16'h280 >> 2] == F_OWN, "R11 next untouched", mem[16'h280 >> 2], F_OWN);

        // R11 resume while inactive
        expect_desc(32'hEA0, 3, 1'b0);
        pulse_resume();
        wait_quiet();
        check(q_active == 1'b1, "R11 resume active", q_active, 1);
        check(cur_desc_addr == 16'h290, "R11 resume cur", cur_desc_addr, 16'h290);
        check(got_n == exp_n, "R11 resume beats", got_n, exp_n);

        // R11 stop while parked, then R10 fresh start
        @(posedge clk); #1; cmd_stop = 1'b1;
        @(posedge clk); #1; cmd_stop = 1'b0;
        repeat (4) @(negedge clk);
        check(q_active == 1'b0, "R11 stop parked", q_active, 0);
        put_desc(16'h2A0, F_OWN | F_IRQ, 32'hEC3, 16'h2B0, 2);
        put_desc(16'h2B0, 32'h0, 32'hEC0, 16'h2C0, 1);
        expect_desc(32'hEC3, 2, 1'b0);
        e0 = done_n;
        bp_en = 1'b0;
        pulse_start(16'h2A0);
        wait_quiet();
        check(cur_desc_addr == 16'h2B0, "R10 start load", cur_desc_addr, 16'h2B0);
        check(got_n == exp_n, "R10 start beats", got_n, exp_n);
        check(done_n == e0 + 1, "R6 done", done_n, e0 + 1);
        check(q_active == 1'b1, "R10 active", q_active, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule